// File: doc/BRIEF.md
# Cable Fault Peak Classifier

This block turns the raw results of a time-domain reflectometry measurement on a single twisted pair into a verdict: the cable is healthy, open, or shorted. It receives a gain index, the amplitudes of the strongest positive and negative reflection peaks, a time word for each peak, and an optional hybrid positive-peak position. A one-cycle start strobe captures all of these. Exactly two clocks later the block raises a one-cycle result pulse carrying a 2-bit verdict.

Each time word packs a coarse cycle count above a fine phase. The block expands both words into a single position measured in phases. A fault is reported only when three things hold. First, the two peaks lie a bounded distance apart. Second, the hybrid position sits ahead of them within a jitter allowance. Third, both amplitudes rise above a noise floor while the gain index is valid. The peak that arrives later decides the kind of fault.

The input side is a strobe with no back-pressure: the block accepts a new measurement on every cycle, and back-to-back strobes produce back-to-back result pulses. The output side offers no ready signal. The consumer must take `res_code` in the cycle where `res_valid` is high. `res_code` holds its value until the next pulse.

Top module: `tdr_fault_classifier`

## Requirements
- R1: A time word holds the cycle count in bits 13:7 and the phase in bits 6:0. Its position is cycle × 96 + phase. A phase value from 96 to 127 is added as is and is not wrapped.
- R2: When the positive-peak position exceeds the negative-peak position by a separation that passes the window, `res_code` is 2 (short).
- R3: When the negative-peak position exceeds the positive-peak position by a separation that passes the window, `res_code` is 1 (open).
- R4: The separation window accepts at least 96 phases and fewer than 185 phases. A separation of 95 or 185 gives code 0 (OK), and a separation of 96 or 184 gives a fault code.
- R5: A fault also needs the hybrid position to be below the later peak's position and below the earlier peak's position plus 30. A hybrid value equal to the earlier position plus 30 gives code 0.
- R6: A fault code is issued only when both amplitudes are strictly above 20 and the gain index, read as two's complement, is non-negative. Otherwise `res_code` is 0.
- R7: `res_valid` is high for one cycle, two clocks after each cycle in which `start` is high. It is high at no other time, including when strobes come back to back.
- R8: All inputs are captured when `start` is high. Changes on them in later cycles do not alter that measurement's verdict.
- R9: After reset, `res_valid` and `res_code` are 0. Code 3 is reserved for diagnostic error and is never issued by the classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe for one measurement |
| gain_idx | input | GAIN_W (16) | Gain index, two's complement; negative means invalid |
| pos_amp | input | AMP_W (16) | Positive peak amplitude |
| neg_amp | input | AMP_W (16) | Negative peak amplitude |
| pos_time | input | CYC_W+PH_W (14) | Positive peak time word {cycle, phase} |
| neg_time | input | CYC_W+PH_W (14) | Negative peak time word {cycle, phase} |
| hyb_pos | input | POS_W (14) | Hybrid positive-peak position in phases; tie to 0 when unused |
| res_valid | output | 1 | One-cycle verdict pulse |
| res_code | output | 2 | 0 OK, 1 open, 2 short, 3 diagnostic error |

## Verification
The bench builds the block with its default parameters: 96 phases per cycle, a 96-phase minimum separation with an 89-phase span, a 30-phase jitter allowance and a noise floor of 20. These defaults keep every decision edge small enough to hit exactly with directed cases. The covered edges are separations of 95, 96, 184 and 185, the hybrid limit at earlier + 29 and earlier + 30, amplitudes of 20 and 21, and a gain index of −1 and 0. Random stimulus places the two peaks within ±250 phases of each other so that both fault orders are exercised often. It also sends raw time words whose phase field is 96 to 127.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_OPEN  = 2'd1,
    RES_SHORT = 2'd2,
    RES_DIAG  = 2'd3
  } res_code_e;

  // Bits needed for the largest position: max cycle * per-cycle + max phase.
  function automatic int pos_bits(int cyc_w, int ph_w, int per_cyc);
    return $clog2(((1 << cyc_w) - 1) * per_cyc + (1 << ph_w));
  endfunction

endpackage

// File: rtl/tfc_pos_conv.sv
module tfc_pos_conv #(
  parameter int CYC_W   = 7,
  parameter int PH_W    = 7,
  parameter int PER_CYC = 96,
  parameter int POS_W   = 14
) (
  input  logic [CYC_W+PH_W-1:0] tword,
  output logic [POS_W-1:0]      pos
);
  logic [CYC_W-1:0] cyc;
  logic [PH_W-1:0]  ph;

  assign {cyc, ph} = tword;
  assign pos = POS_W'(cyc) * POS_W'(PER_CYC) + POS_W'(ph);
endmodule

// File: rtl/tfc_window_chk.sv
module tfc_window_chk #(
  parameter int POS_W    = 14,
  parameter int MIN_SEP  = 96,
  parameter int SEP_SPAN = 89,
  parameter int JITTER   = 30
) (
  input  logic [POS_W-1:0] later,
  input  logic [POS_W-1:0] earlier,
  input  logic [POS_W-1:0] hyb,
  output logic             pass
);
  localparam int D_W = POS_W + 2;
  typedef logic signed [D_W-1:0] sd_t;
  localparam sd_t LO  = sd_t'(MIN_SEP);
  localparam sd_t HI  = sd_t'(MIN_SEP + SEP_SPAN);
  localparam sd_t JIT = sd_t'(JITTER);

  sd_t later_s, earlier_s, hyb_s, sep;

  assign later_s   = sd_t'({2'b00, later});
  assign earlier_s = sd_t'({2'b00, earlier});
  assign hyb_s     = sd_t'({2'b00, hyb});
  assign sep       = later_s - earlier_s;

  assign pass = (sep >= LO) && (sep < HI) &&
                (hyb_s < later_s) && (hyb_s < earlier_s + JIT);
endmodule

// File: rtl/tdr_fault_classifier.sv
module tdr_fault_classifier #(
  parameter int CYC_W    = 7,
  parameter int PH_W     = 7,
  parameter int PER_CYC  = 96,
  parameter int MIN_SEP  = 96,
  parameter int SEP_SPAN = 89,
  parameter int JITTER   = 30,
  parameter int NOISE    = 20,
  parameter int AMP_W    = 16,
  parameter int GAIN_W   = 16,
  parameter int POS_W    = tfc_pkg::pos_bits(CYC_W, PH_W, PER_CYC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [GAIN_W-1:0]      gain_idx,
  input  logic [AMP_W-1:0]       pos_amp,
  input  logic [AMP_W-1:0]       neg_amp,
  input  logic [CYC_W+PH_W-1:0]  pos_time,
  input  logic [CYC_W+PH_W-1:0]  neg_time,
  input  logic [POS_W-1:0]       hyb_pos,
  output logic                   res_valid,
  output logic [1:0]             res_code
);
  import tfc_pkg::*;

  localparam int TW = CYC_W + PH_W;
  localparam int NPK = 2;  // index 0: positive peak, 1: negative peak

  // Stage 1: capture registers
  logic              v1;
  logic [GAIN_W-1:0] gain_q;
  logic [AMP_W-1:0]  amp_q [NPK];
  logic [TW-1:0]     tw_q  [NPK];
  logic [POS_W-1:0]  hyb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      gain_q <= '0;
      hyb_q  <= '0;
      for (int i = 0; i < NPK; i++) begin
        amp_q[i] <= '0;
        tw_q[i]  <= '0;
      end
    end else begin
      v1 <= start;
      if (start) begin
        gain_q   <= gain_idx;
        hyb_q    <= hyb_pos;
        amp_q[0] <= pos_amp;
        amp_q[1] <= neg_amp;
        tw_q[0]  <= pos_time;
        tw_q[1]  <= neg_time;
      end
    end
  end

  // Position expansion for each peak
  logic [POS_W-1:0] pk_pos [NPK];
  logic [NPK-1:0]   win_ok;

  for (genvar g = 0; g < NPK; g++) begin : g_peak
    tfc_pos_conv #(
      .CYC_W(CYC_W), .PH_W(PH_W), .PER_CYC(PER_CYC), .POS_W(POS_W)
    ) u_conv (
      .tword(tw_q[g]),
      .pos  (pk_pos[g])
    );
    // Window g treats peak g as the later one
    tfc_window_chk #(
      .POS_W(POS_W), .MIN_SEP(MIN_SEP), .SEP_SPAN(SEP_SPAN), .JITTER(JITTER)
    ) u_win (
      .later  (pk_pos[g]),
      .earlier(pk_pos[NPK-1-g]),
      .hyb    (hyb_q),
      .pass   (win_ok[g])
    );
  end

  // Verdict
  res_code_e cand, verdict;
  logic      amps_ok, gain_ok;

  always_comb begin
    if (pk_pos[0] > pk_pos[1] && win_ok[0])      cand = RES_SHORT;
    else if (pk_pos[1] > pk_pos[0] && win_ok[1]) cand = RES_OPEN;
    else                                         cand = RES_OK;
    amps_ok = (amp_q[0] > AMP_W'(NOISE)) && (amp_q[1] > AMP_W'(NOISE));
    gain_ok = !gain_q[GAIN_W-1];
    verdict = (amps_ok && gain_ok) ? cand : RES_OK;
  end

  // Stage 2: result registers
  res_code_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      code_q    <= RES_OK;
    end else begin
      res_valid <= v1;
      if (v1) code_q <= verdict;
    end
  end

  assign res_code = code_q;

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 res_valid);

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(start, 2));

  // R6
  noise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (pos_amp <= AMP_W'(NOISE) || neg_amp <= AMP_W'(NOISE)))
      |-> ##2 (res_code == RES_OK));

  // R6
  gain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && gain_idx[GAIN_W-1]) |-> ##2 (res_code == RES_OK));

  // R2
  order_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && pk_pos[0] >= pk_pos[1]) |=> (res_code != RES_OPEN));

  // R3
  order_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && pk_pos[1] >= pk_pos[0]) |=> (res_code != RES_SHORT));

  // R9
  no_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code != RES_DIAG));
endmodule

// File: tb/tdr_fault_classifier_test.sv
module tdr_fault_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] gain = '0;
  logic [15:0] pamp = '0, namp = '0;
  logic [13:0] ptw = '0, ntw = '0, hyb = '0;
  logic        res_valid;
  logic [1:0]  res_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tdr_fault_classifier uut (
    .clk(clk), .rst_n(rst_n), .start(start), .gain_idx(gain),
    .pos_amp(pamp), .neg_amp(namp), .pos_time(ptw), .neg_time(ntw),
    .hyb_pos(hyb), .res_valid(res_valid), .res_code(res_code)
  );

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [13:0] word_of(int p);
    return {7'(p / 96), 7'(p % 96)};
  endfunction

  function automatic int pos_of(logic [13:0] w);
    return int'(w[13:7]) * 96 + int'(w[6:0]);
  endfunction

  // Expected verdict from the requirements (R1..R6)
  function automatic int model(int g, int pa, int na, logic [13:0] pw, logic [13:0] nw, int hy);
    int pp = pos_of(pw);
    int nn = pos_of(nw);
    int c = 0;
    if (pp - nn >= 96 && pp - nn < 185 && hy < pp && hy < nn + 30) c = 2;
    else if (nn - pp >= 96 && nn - pp < 185 && hy < nn && hy < pp + 30) c = 1;
    if (!(pa > 20 && na > 20 && g >= 0)) c = 0;
    return c;
  endfunction

  task automatic drive(int g, int pa, int na, logic [13:0] pw, logic [13:0] nw, int hy);
    gain = 16'(g); pamp = 16'(pa); namp = 16'(na);
    ptw = pw; ntw = nw; hyb = 14'(hy);
  endtask

  // One measurement, called at a negedge; returns at the negedge of the pulse
  task automatic run_w(string tag, int g, int pa, int na, logic [13:0] pw, logic [13:0] nw, int hy);
    int exp = model(g, pa, na, pw, nw, hy);
    drive(g, pa, na, pw, nw, hy);
    start = 1'b1;
    @(negedge clk);
    check({tag, " R7 valid low one cycle after start"}, res_valid, 0);
    start = 1'b0;
    // R8: disturb every input after capture
    drive(int'($urandom_range(0, 300)), int'($urandom_range(0, 99)), int'($urandom_range(0, 99)),
          14'($urandom), 14'($urandom), int'($urandom_range(0, 200)));
    @(negedge clk);
    check({tag, " R7 valid two clocks after start"}, res_valid, 1);
    check({tag, " R8 code"}, res_code, exp);
  endtask

  task automatic run(string tag, int g, int pa, int na, int pp, int nn, int hy);
    run_w(tag, g, pa, na, word_of(pp), word_of(nn), hy);
  endtask

  initial begin
    int e1, e2;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    check("R9 reset valid", res_valid, 0);
    check("R9 reset code", res_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle valid", res_valid, 0);

    // R1: field split and unwrapped phase
    run_w("R1 cyc2 ph5 vs 50", 5, 40, 40, {7'd2, 7'd5}, {7'd0, 7'd50}, 0);
    run_w("R1 phase 100", 5, 40, 40, {7'd1, 7'd100}, {7'd0, 7'd90}, 0);
    run_w("R1 phase 127 gap", 5, 40, 40, {7'd1, 7'd127}, {7'd0, 7'd0}, 0);
    // R2 / R3 main cases
    run("R2 short 120", 3, 50, 50, 620, 500, 0);
    run("R3 open 120", 3, 50, 50, 500, 620, 0);
    run("R2 equal positions", 3, 50, 50, 500, 500, 0);
    // R4 window edges
    run("R4 sep 95", 1, 30, 30, 1095, 1000, 0);
    run("R4 sep 96", 1, 30, 30, 1096, 1000, 0);
    run("R4 sep 184", 1, 30, 30, 1184, 1000, 0);
    run("R4 sep 185", 1, 30, 30, 1185, 1000, 0);
    run("R4 open sep 96", 1, 30, 30, 1000, 1096, 0);
    run("R4 open sep 185", 1, 30, 30, 1000, 1185, 0);
    // R5 hybrid limits
    run("R5 hyb earlier+29", 1, 30, 30, 1150, 1000, 1029);
    run("R5 hyb earlier+30", 1, 30, 30, 1150, 1000, 1030);
    run("R5 open hyb earlier+30", 1, 30, 30, 1000, 1150, 1030);
    // R6 gates
    run("R6 amp 20", 1, 20, 40, 1150, 1000, 0);
    run("R6 amp 21", 1, 21, 21, 1150, 1000, 0);
    run("R6 neg amp 20", 1, 40, 20, 1000, 1150, 0);
    run("R6 gain -1", -1, 40, 40, 1150, 1000, 0);
    run("R6 gain 0", 0, 40, 40, 1150, 1000, 0);

    // R7 back-to-back strobes
    e1 = model(2, 40, 40, word_of(700), word_of(580), 0);
    e2 = model(2, 40, 40, word_of(580), word_of(700), 0);
    drive(2, 40, 40, word_of(700), word_of(580), 0);
    start = 1'b1;
    @(negedge clk);
    check("R7 b2b valid low", res_valid, 0);
    drive(2, 40, 40, word_of(580), word_of(700), 0);
    @(negedge clk);
    start = 1'b0;
    check("R7 b2b first valid", res_valid, 1);
    check("R7 b2b first code", res_code, e1);
    @(negedge clk);
    check("R7 b2b second valid", res_valid, 1);
    check("R7 b2b second code", res_code, e2);
    @(negedge clk);
    check("R7 b2b pulse ends", res_valid, 0);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int g, pa, na, pp, nn, hy;
      logic [13:0] pw, nw;
      g  = ($urandom_range(0, 7) == 0) ? -int'($urandom_range(1, 500)) : int'($urandom_range(0, 500));
      pa = int'($urandom_range(10, 60));
      na = int'($urandom_range(10, 60));
      nn = int'($urandom_range(0, 12000));
      pp = nn + int'($urandom_range(0, 500)) - 250;
      if (pp < 0) pp = 0;
      if (pp > 12287) pp = 12287;
      pw = word_of(pp);
      nw = word_of(nn);
      if ($urandom_range(0, 9) == 0) begin
        pw = 14'($urandom);
        nw = {pw[13:7], 7'($urandom)};
      end
      hy = 0;
      if ($urandom_range(0, 2) == 0) begin
        hy = ((pp < nn) ? pp : nn) + int'($urandom_range(0, 60)) - 30;
        if (hy < 0) hy = 0;
      end
      run_w("R2/R3/R5/R6 random", g, pa, na, pw, nw, hy);
    end
    @(negedge clk);
    check("R7 idle after last", res_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule